// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a small processing datapath. It holds eight general registers, has an arithmetic, logic and shift function unit, and produces four status flags. A sequencer outside the block applies one 16-bit control word in each clock cycle. That word chooses two source registers and the second operand. It also chooses the operation, where the write data comes from, and whether a destination register is loaded at the next rising edge.

The first operand (bus A) comes from a register and also leaves the block as an address output. The second operand (bus B) is either a register or an external constant, and it also leaves the block as a data output. The value written back is either the function unit result or an external data input. The flags describe the result the function unit is producing in the current cycle.

Top module: `cw_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, all eight registers are cleared to zero, and every register then reads zero.
- R2: The control word is split MSB first into: destination index [15:13], A index [12:10], B index [9:7], operand select [6], function code [5:2], write-source select [1] and write enable [0]. `addr_out` shows the register chosen by the A index combinationally, whatever the value of the write enable.
- R3: When bit [6] is 0, `data_out` (bus B) shows the register chosen by the B index. When bit [6] is 1, it shows `const_in`.
- R4: When bit [1] is 0, the value written is the function unit result. When bit [1] is 1, it is `data_in`.
- R5: When bit [0] is 1, the destination register takes the write value at the rising edge. A read of that register in the same cycle still shows the old value, and the new value appears from the next cycle on.
- R6: When bit [0] is 0, no register changes, whatever the other fields hold.
- R7: Function codes 0000 to 0111 are arithmetic. In that order they give A, A+1, A+B, A+B+1, A+~B, A+~B+1, A−1 and A. Each is computed as A + Y + cin, where Y is 0, B, ~B or all ones (selected by code bits [2:1]) and cin is code bit [0].
- R8: Function codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A.
- R9: The shifter is chosen when code bits [3] and [2] are both 1. Code 1100 passes B, 1101 shifts B right by one, 1110 shifts B left by one, and 1111 passes B. Each vacated bit is filled with 0.
- R10: `flag_n` equals the MSB of the result, and `flag_z` is 1 exactly when the result is zero.
- R11: For arithmetic codes, `flag_c` is the carry out of A + Y + cin, and `flag_v` is two's-complement overflow (A and Y have the same sign but the result has the other sign). For logic and shift codes, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_word | input | 16 | Control word for the current cycle |
| const_in | input | WIDTH | External constant for bus B |
| data_in | input | WIDTH | External write data |
| addr_out | output | WIDTH | Bus A value |
| data_out | output | WIDTH | Bus B value |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |
| flag_n | output | 1 | Result sign |
| flag_z | output | 1 | Result zero |

## Verification
Registers are loaded with a set of distinct values: small numbers, 0x7F, 0x80 and 0xFF. The stimulus then runs every function code on them. Signed overflow, unsigned carry, wrap to zero and a decrement of zero each leave their own flag pattern. A read of the register being written in that same cycle separates the old value from the new one. Three other cases catch swapped selects: a control word with the write enable low but every other field active, a forced reset in the middle of the run, and the two operand sources checked against each other.

// File: rtl/cw_datapath.sv
module cw_datapath #(
  parameter int WIDTH = 8,
  parameter int NREG  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [15:0]      ctrl_word,
  input  logic [WIDTH-1:0] const_in,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] addr_out,
  output logic [WIDTH-1:0] data_out,
  output logic             flag_v,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_z
);
  localparam int AW = $clog2(NREG);
  localparam int CW = 3 * AW + 7;

  logic [NREG-1:0][WIDTH-1:0] rf;

  wire [AW-1:0] dst_i = ctrl_word[CW-1 -: AW];
  wire [AW-1:0] a_i   = ctrl_word[CW-1-AW -: AW];
  wire [AW-1:0] b_i   = ctrl_word[CW-1-2*AW -: AW];
  wire          b_src = ctrl_word[6];
  wire [3:0]    fcode = ctrl_word[5:2];
  wire          w_src = ctrl_word[1];
  wire          w_en  = ctrl_word[0];

  wire [WIDTH-1:0] bus_a = rf[a_i];
  wire [WIDTH-1:0] bus_b = b_src ? const_in : rf[b_i];

  logic [WIDTH-1:0] y_in;
  always_comb begin
    case (fcode[2:1])
      2'b00:   y_in = '0;
      2'b01:   y_in = bus_b;
      2'b10:   y_in = ~bus_b;
      default: y_in = '1;
    endcase
  end

  wire [WIDTH:0] sum = {1'b0, bus_a} + {1'b0, y_in} + {{WIDTH{1'b0}}, fcode[0]};
  wire ovf = (bus_a[WIDTH-1] == y_in[WIDTH-1]) && (sum[WIDTH-1] != bus_a[WIDTH-1]);

  logic [WIDTH-1:0] logic_res;
  always_comb begin
    case (fcode[1:0])
      2'b00:   logic_res = bus_a & bus_b;
      2'b01:   logic_res = bus_a | bus_b;
      2'b10:   logic_res = bus_a ^ bus_b;
      default: logic_res = ~bus_a;
    endcase
  end

  logic [WIDTH-1:0] shift_res;
  always_comb begin
    case (fcode[1:0])
      2'b01:   shift_res = {1'b0, bus_b[WIDTH-1:1]};
      2'b10:   shift_res = {bus_b[WIDTH-2:0], 1'b0};
      default: shift_res = bus_b;
    endcase
  end

  wire sel_shift = fcode[3] & fcode[2];
  wire [WIDTH-1:0] result = sel_shift ? shift_res : (fcode[3] ? logic_res : sum[WIDTH-1:0]);
  wire [WIDTH-1:0] wdata  = w_src ? data_in : result;

  always_ff @(posedge clk) begin
    if (rst)       rf <= '0;
    else if (w_en) rf[dst_i] <= wdata;
  end

  assign addr_out = bus_a;
  assign data_out = bus_b;
  assign flag_c   = ~fcode[3] & sum[WIDTH];
  assign flag_v   = ~fcode[3] & ovf;
  assign flag_n   = result[WIDTH-1];
  assign flag_z   = ~|result;

  assert_clear_R1: assert property (@(posedge clk) rst |=> rf == '0);
  assert_write_R5: assert property (@(posedge clk) disable iff (rst)
    w_en |=> rf[$past(dst_i)] == $past(wdata));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !w_en |=> $stable(rf));
  assert_zn_R10: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> !flag_n);
  assert_passnocarry_R11: assert property (@(posedge clk) disable iff (rst)
    (fcode == 4'b0000) |-> (!flag_c && !flag_v && addr_out == (flag_z ? '0 : addr_out)));
endmodule

// File: tb/sim_cw_datapath.sv
module sim_cw_datapath;
  localparam int W = 8;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [15:0] ctrl_word = '0;
  logic [W-1:0] const_in = '0, data_in = '0;
  logic [W-1:0] addr_out, data_out;
  logic flag_v, flag_c, flag_n, flag_z;

  cw_datapath #(.WIDTH(W), .NREG(8)) u0 (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .const_in(const_in), .data_in(data_in),
    .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z));

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] a, b;
    logic [3:0] fl;
    string tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0;
  logic [W-1:0] model [8];

  function automatic logic [15:0] cw(int da, int aa, int ba, bit mb, logic [3:0] fs, bit md, bit rw);
    return {da[2:0], aa[2:0], ba[2:0], mb, fs, md, rw};
  endfunction

  task automatic fu(input logic [3:0] fs, input logic [W-1:0] a, b,
                    output logic [W-1:0] f, output logic c, v);
    logic [W:0] s;
    logic [W-1:0] y;
    c = 0; v = 0; y = '0; s = '0;
    case (fs)
      4'h0: begin y = '0;  s = a + y; end
      4'h1: begin y = '0;  s = a + y + 1; end
      4'h2: begin y = b;   s = a + y; end
      4'h3: begin y = b;   s = a + y + 1; end
      4'h4: begin y = ~b;  s = a + y; end
      4'h5: begin y = ~b;  s = a + y + 1; end
      4'h6: begin y = '1;  s = a + y; end
      4'h7: begin y = '1;  s = a + y + 1; end
      default: ;
    endcase
    if (!fs[3]) begin
      f = s[W-1:0]; c = s[W];
      v = (a[W-1] == y[W-1]) && (f[W-1] != a[W-1]);
    end else case (fs)
      4'h8: f = a & b;
      4'h9: f = a | b;
      4'hA: f = a ^ b;
      4'hB: f = ~a;
      4'hD: f = b >> 1;
      4'hE: f = b << 1;
      default: f = b;
    endcase
  endtask

  task automatic step(input int da, aa, ba, input bit mb, input logic [3:0] fs,
                      input bit md, rw, input logic [W-1:0] k, d, input string tag);
    exp_t e;
    logic [W-1:0] a, b, f;
    logic c, v;
    @(negedge clk);
    ctrl_word = cw(da, aa, ba, mb, fs, md, rw);
    const_in = k; data_in = d;
    a = model[aa]; b = mb ? k : model[ba];
    fu(fs, a, b, f, c, v);
    e.a = a; e.b = b; e.fl = {v, c, f[W-1], f == '0}; e.tag = tag;
    sb.push_back(e);
    if (rw) model[da] = md ? d : f;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 8; i++) model[i] = '0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk); #(PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (addr_out !== e.a) begin fails++; $display("FAIL %s addr_out act=%h exp=%h", e.tag, addr_out, e.a); end
        checks++;
        if (data_out !== e.b) begin fails++; $display("FAIL %s data_out act=%h exp=%h", e.tag, data_out, e.b); end
        checks++;
        if ({flag_v, flag_c, flag_n, flag_z} !== e.fl) begin
          fails++; $display("FAIL %s flags VCNZ act=%b exp=%b", e.tag, {flag_v, flag_c, flag_n, flag_z}, e.fl);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    for (int i = 0; i < 8; i++) step(0, i, 7 - i, 0, 4'h0, 0, 0, 8'h00, 8'h00, "R1 reset");
    // R4 R5 load through data_in
    step(1, 0, 0, 0, 4'h0, 1, 1, 8'h00, 8'h05, "R4 load");
    step(2, 1, 0, 0, 4'h0, 1, 1, 8'h00, 8'h03, "R4 load");
    step(3, 2, 1, 0, 4'h0, 1, 1, 8'h00, 8'h7F, "R4 load");
    step(4, 3, 2, 0, 4'h0, 1, 1, 8'h00, 8'h80, "R4 load");
    step(5, 4, 3, 0, 4'h0, 1, 1, 8'h00, 8'hFF, "R4 load");
    step(6, 5, 4, 0, 4'h0, 1, 1, 8'h00, 8'h1C, "R4 load");
    step(7, 6, 5, 0, 4'h0, 1, 1, 8'h00, 8'h07, "R4 load");
    // R2 R3 sources
    step(0, 1, 2, 0, 4'hC, 0, 0, 8'h99, 8'h00, "R2 read ports");
    step(0, 7, 6, 1, 4'hC, 0, 0, 8'h99, 8'h00, "R3 const operand");
    // R5 no bypass
    step(1, 1, 1, 0, 4'h0, 1, 1, 8'h00, 8'hAA, "R5 same-cycle old");
    step(0, 1, 1, 0, 4'h0, 0, 0, 8'h00, 8'h00, "R5 next-cycle new");
    step(1, 0, 0, 0, 4'h0, 1, 1, 8'h00, 8'h05, "R5 restore");
    // R7 R11 arithmetic
    step(0, 3, 4, 0, 4'h2, 0, 0, 8'h00, 8'h00, "R7 R11 add 7F+80");
    step(0, 3, 0, 0, 4'h1, 0, 0, 8'h00, 8'h00, "R11 inc overflow");
    step(0, 5, 0, 1, 4'h2, 0, 0, 8'h01, 8'h00, "R10 R11 wrap to zero");
    step(0, 2, 1, 0, 4'h5, 0, 0, 8'h00, 8'h00, "R7 sub 3-5");
    step(0, 1, 2, 0, 4'h5, 0, 0, 8'h00, 8'h00, "R7 sub 5-3");
    step(0, 0, 0, 0, 4'h6, 0, 0, 8'h00, 8'h00, "R7 R10 dec zero");
    step(0, 4, 0, 1, 4'h4, 0, 0, 8'h01, 8'h00, "R7 R11 A+~B");
    step(0, 4, 0, 1, 4'h3, 0, 0, 8'h80, 8'h00, "R7 R11 A+B+1");
    step(0, 7, 6, 0, 4'h7, 0, 0, 8'h00, 8'h00, "R7 code 0111");
    step(0, 4, 0, 0, 4'h0, 0, 0, 8'h00, 8'h00, "R11 pass");
    // R8 logic
    step(0, 5, 0, 1, 4'h8, 0, 0, 8'h3C, 8'h00, "R8 and");
    step(0, 1, 0, 1, 4'h9, 0, 0, 8'h30, 8'h00, "R8 or");
    step(0, 5, 5, 0, 4'hA, 0, 0, 8'h00, 8'h00, "R8 R10 xor zero");
    step(0, 4, 0, 0, 4'hB, 0, 0, 8'h00, 8'h00, "R8 not");
    // R9 shifter
    step(0, 0, 4, 0, 4'hE, 0, 0, 8'h00, 8'h00, "R9 shl out");
    step(0, 0, 5, 0, 4'hD, 0, 0, 8'h00, 8'h00, "R9 shr");
    step(0, 0, 3, 0, 4'hE, 0, 0, 8'h00, 8'h00, "R9 shl");
    step(0, 0, 0, 1, 4'hF, 0, 0, 8'hC3, 8'h00, "R9 code 1111");
    // R4 result write, R6 hold
    step(6, 1, 2, 0, 4'h2, 0, 1, 8'h00, 8'h00, "R4 write result");
    step(2, 6, 2, 0, 4'h2, 1, 0, 8'h00, 8'h55, "R6 no write");
    step(0, 2, 6, 0, 4'h0, 0, 0, 8'h00, 8'h00, "R6 R4 readback");
    // R1 mid-run reset
    do_reset();
    for (int i = 0; i < 8; i++) step(0, i, i, 0, 4'h2, 0, 0, 8'h00, 8'h00, "R1 mid reset");
    repeat (3) @(negedge clk);
    #(PERIOD/2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule